// File: doc/BRIEF.md
# I2C Master Transfer Status Word

This block keeps the status flags that a host reads back from an I2C master controller. The master's command sequencer pulses event strobes into it: lost arbitration, a NAK after the address byte, a NAK after a written data byte, a bus timer expiry, a Stop seen on the bus, and the transmit and receive phase markers. The block holds the error events until software has seen them. It tracks whether a transmit, or a write-then-read sequence, is still running. It also forms a summary bit that says a transfer was cut short.

The host sees everything as one 16-bit word on `rd_data_o`. The word is combinational from the stored state, so a read strobe in a cycle returns the value from before the read. Any clearing that the read causes takes effect at the next clock edge. Issuing a new command also wipes the error flags, but it leaves the in-progress flags untouched.

Top module: `i2c_xfer_status`

## Requirements
- R1: Bit 15 (arbitration lost) becomes 1 in the cycle after `arb_lost_i` and stays 1 until a cycle with `rd_i` or `cmd_new_i`, after which it reads 0.
- R2: Bit 5 (NAK on address) and bit 4 (NAK on written data) set from `nak_addr_i` and `nak_data_i`, are sticky, and clear after a cycle with `rd_i` or `cmd_new_i`.
- R3: Bit 14 (timeout) does not set on `timeout_i` alone. It sets after the first `stop_i` in a later cycle than the timeout. A `cmd_new_i` in between cancels the pending timeout. Once set, bit 14 clears after `rd_i` or `cmd_new_i`.
- R4: Bit 3 (transfer stopped) equals the OR of bits 15, 14 and 10 down to 4 of the word in every cycle.
- R5: Bit 1 (transmit busy) sets after `tx_start_i`. It clears only after a `rd_i` in a cycle strictly later than a `tx_done_i`. A read in the same cycle as `tx_done_i`, or before it, leaves bit 1 set.
- R6: A `tx_to_rx_i` pulse clears bit 1 at the next edge, without any read.
- R7: Bit 2 (sequence busy) sets after `tx_start_i` with `seq_cmd_i` high. It clears only after a `rd_i` in a cycle strictly later than a `rx_done_i`.
- R8: When a set event and a clearing read or new command fall in the same cycle, the flag reads 1 afterwards.
- R9: `rd_data_o` during a `rd_i` cycle shows the value from before the read; the clear appears from the next cycle on.
- R10: After reset the word is 0. Bits 13 to 11, 10 to 6 and 0 always read 0.
- R11: `cmd_new_i` does not clear bit 1 or bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| arb_lost_i | input | 1 | Strobe: a transfer lost bus arbitration |
| nak_addr_i | input | 1 | Strobe: NAK after the address byte |
| nak_data_i | input | 1 | Strobe: NAK after a transmitted data byte |
| timeout_i | input | 1 | Strobe: bus timer expired during a read |
| stop_i | input | 1 | Strobe: Stop condition seen on the bus |
| tx_start_i | input | 1 | Strobe: transmit part of a command begins |
| seq_cmd_i | input | 1 | Qualifier with `tx_start_i`: command is write-then-read |
| tx_done_i | input | 1 | Strobe: transmit part finished |
| tx_to_rx_i | input | 1 | Strobe: sequence command switches to its receive part |
| rx_done_i | input | 1 | Strobe: receive part finished |
| cmd_new_i | input | 1 | Strobe from host: a new command is issued |
| rd_i | input | 1 | Strobe from host: status word is read this cycle |
| rd_data_o | output | 16 | Status word |

## Verification
Directed steps check each flag on its own: a lone set, then clearing by read and clearing by new command. They also cover the two ordering cases that decide whether a flag clears. A read in the same cycle as a phase completion must leave the busy flag set, while a read one cycle later clears it. A timeout without a later Stop must not raise bit 14. Set and clear in the same cycle is tried separately from a clear alone, which tells whether set priority is in place. A long seeded random run then drives all strobes at low density against a bench model. That run exposes interactions the directed steps miss, such as a switch to receive arriving together with a completion, or a new command between a timeout and its Stop.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned BIT_ARB  = 15;
  localparam int unsigned BIT_TMO  = 14;
  localparam int unsigned ERR_HI   = 10;
  localparam int unsigned ERR_LO   = 4;
  localparam int unsigned BIT_NAKA = 5;
  localparam int unsigned BIT_NAKD = 4;
  localparam int unsigned BIT_STOP = 3;
  localparam int unsigned BIT_SEQ  = 2;
  localparam int unsigned BIT_TX   = 1;
  localparam int unsigned N_ERR    = 3;

  typedef enum logic [1:0] {
    ERR_ARB  = 2'd0,
    ERR_NAKA = 2'd1,
    ERR_NAKD = 2'd2
  } err_idx_e;
endpackage

// File: rtl/i2c_sticky_flag.sv
module i2c_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr_i) flag_d = 1'b0;
    if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/i2c_timeout_flag.sv
module i2c_timeout_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic tmo_i,
  input  logic stop_i,
  input  logic cmd_i,
  input  logic rd_i,
  output logic flag_o
);
  logic pend_q, pend_d;
  logic flag_q, flag_d;

  always_comb begin
    pend_d = pend_q;
    if (stop_i || cmd_i) pend_d = 1'b0;
    if (tmo_i)           pend_d = 1'b1;

    flag_d = flag_q;
    if (rd_i || cmd_i)     flag_d = 1'b0;
    if (pend_q && stop_i)  flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/i2c_phase_flag.sv
module i2c_phase_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic done_i,
  input  logic abort_i,
  input  logic rd_i,
  output logic busy_o
);
  logic busy_q, busy_d;
  logic mark_q, mark_d;

  always_comb begin
    busy_d = busy_q;
    mark_d = mark_q;
    if (start_i) begin
      busy_d = 1'b1;
      mark_d = 1'b0;
    end else if (abort_i) begin
      busy_d = 1'b0;
      mark_d = 1'b0;
    end else if (rd_i && mark_q) begin
      busy_d = 1'b0;
      mark_d = 1'b0;
    end else if (done_i && busy_q) begin
      mark_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      mark_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      mark_q <= mark_d;
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/i2c_xfer_status.sv
module i2c_xfer_status
  import i2c_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arb_lost_i,
  input  logic              nak_addr_i,
  input  logic              nak_data_i,
  input  logic              timeout_i,
  input  logic              stop_i,
  input  logic              tx_start_i,
  input  logic              seq_cmd_i,
  input  logic              tx_done_i,
  input  logic              tx_to_rx_i,
  input  logic              rx_done_i,
  input  logic              cmd_new_i,
  input  logic              rd_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic [N_ERR-1:0] err_ev;
  logic [N_ERR-1:0] err_q;
  logic             err_clr;

  assign err_clr          = rd_i | cmd_new_i;
  assign err_ev[ERR_ARB]  = arb_lost_i;
  assign err_ev[ERR_NAKA] = nak_addr_i;
  assign err_ev[ERR_NAKD] = nak_data_i;

  for (genvar g = 0; g < N_ERR; g++) begin : g_err
    i2c_sticky_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .set_i  (err_ev[g]),
      .clr_i  (err_clr),
      .flag_o (err_q[g])
    );
  end

  logic tmo_q;
  i2c_timeout_flag u_tmo (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tmo_i  (timeout_i),
    .stop_i (stop_i),
    .cmd_i  (cmd_new_i),
    .rd_i   (rd_i),
    .flag_o (tmo_q)
  );

  logic tx_busy, seq_busy;
  i2c_phase_flag u_tx (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (tx_start_i),
    .done_i  (tx_done_i),
    .abort_i (tx_to_rx_i),
    .rd_i    (rd_i),
    .busy_o  (tx_busy)
  );

  i2c_phase_flag u_seq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (tx_start_i & seq_cmd_i),
    .done_i  (rx_done_i),
    .abort_i (1'b0),
    .rd_i    (rd_i),
    .busy_o  (seq_busy)
  );

  logic [WORD_W-1:0] word;
  always_comb begin
    word               = '0;
    word[BIT_ARB]      = err_q[ERR_ARB];
    word[BIT_TMO]      = tmo_q;
    word[BIT_NAKA]     = err_q[ERR_NAKA];
    word[BIT_NAKD]     = err_q[ERR_NAKD];
    word[BIT_SEQ]      = seq_busy;
    word[BIT_TX]       = tx_busy;
    word[BIT_STOP]     = word[BIT_ARB] | word[BIT_TMO] | (|word[ERR_HI:ERR_LO]);
  end

  assign rd_data_o = word;
endmodule

// File: rtl/i2c_xfer_status_chk.sv
module i2c_xfer_status_chk (
  input logic        clk,
  input logic        rst_ok,
  input logic        arb_lost_i,
  input logic        stop_i,
  input logic        tx_start_i,
  input logic        seq_cmd_i,
  input logic        tx_to_rx_i,
  input logic        cmd_new_i,
  input logic        rd_i,
  input logic [15:0] rd_data_o
);
  // R1
  arb_set_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    arb_lost_i |=> rd_data_o[15]);

  // R1
  arb_clear_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    ((rd_i || cmd_new_i) && !arb_lost_i) |=> !rd_data_o[15]);

  // R3
  tmo_needs_stop_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(rd_data_o[14]) |-> $past(stop_i));

  // R4
  stopped_sum_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (rd_data_o[15] || rd_data_o[14] || rd_data_o[5] || rd_data_o[4]) |-> rd_data_o[3]);

  // R5
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (rd_data_o[1] && !rd_i && !tx_to_rx_i) |=> rd_data_o[1]);

  // R6
  tx_switch_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (tx_to_rx_i && !tx_start_i) |=> !rd_data_o[1]);

  // R7
  seq_set_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (tx_start_i && seq_cmd_i) |=> (rd_data_o[2] && rd_data_o[1]));

  // R11
  cmd_keep_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (rd_data_o[2] && cmd_new_i && !rd_i) |=> rd_data_o[2]);
endmodule

bind i2c_xfer_status i2c_xfer_status_chk u_chk (
  .clk        (clk),
  .rst_ok     (rst_sync_n),
  .arb_lost_i (arb_lost_i),
  .stop_i     (stop_i),
  .tx_start_i (tx_start_i),
  .seq_cmd_i  (seq_cmd_i),
  .tx_to_rx_i (tx_to_rx_i),
  .cmd_new_i  (cmd_new_i),
  .rd_i       (rd_i),
  .rd_data_o  (rd_data_o)
);

// File: tb/i2c_xfer_status_test.sv
`timescale 1ns/1ps
module i2c_xfer_status_test;
  logic clk = 1'b0;
  logic rst_n;
  logic arb_lost_i, nak_addr_i, nak_data_i, timeout_i, stop_i;
  logic tx_start_i, seq_cmd_i, tx_done_i, tx_to_rx_i, rx_done_i;
  logic cmd_new_i, rd_i;
  logic [15:0] rd_data_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  i2c_xfer_status uut (.*);

  // bench model state
  bit m_arb, m_naka, m_nakd, m_pend, m_tmo, m_tx, m_txm, m_seq, m_seqm;

  function automatic logic [15:0] exp_word();
    logic [15:0] w = '0;
    w[15] = m_arb; w[14] = m_tmo; w[5] = m_naka; w[4] = m_nakd;
    w[3]  = m_arb | m_tmo | m_naka | m_nakd;
    w[2]  = m_seq; w[1] = m_tx;
    return w;
  endfunction

  task automatic model_step();
    bit clr = rd_i | cmd_new_i;
    bit tmo_n = (m_pend & stop_i) | (m_tmo & ~clr);
    m_pend = timeout_i | (m_pend & ~stop_i & ~cmd_new_i);
    m_tmo  = tmo_n;
    m_arb  = arb_lost_i | (m_arb  & ~clr);
    m_naka = nak_addr_i | (m_naka & ~clr);
    m_nakd = nak_data_i | (m_nakd & ~clr);
    if (tx_start_i)            begin m_tx = 1; m_txm = 0; end
    else if (tx_to_rx_i)       begin m_tx = 0; m_txm = 0; end
    else if (rd_i && m_txm)    begin m_tx = 0; m_txm = 0; end
    else if (tx_done_i && m_tx) m_txm = 1;
    if (tx_start_i && seq_cmd_i) begin m_seq = 1; m_seqm = 0; end
    else if (rd_i && m_seqm)     begin m_seq = 0; m_seqm = 0; end
    else if (rx_done_i && m_seq) m_seqm = 1;
  endtask

  task automatic idle_inputs();
    {arb_lost_i, nak_addr_i, nak_data_i, timeout_i, stop_i} = '0;
    {tx_start_i, seq_cmd_i, tx_done_i, tx_to_rx_i, rx_done_i} = '0;
    {cmd_new_i, rd_i} = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    void'($urandom(32'd5150));
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset value
    chk("R10 reset", rd_data_o, 16'h0000);

    // R1 / R4 / R9
    arb_lost_i = 1; tick();
    chk("R1 arb set", rd_data_o, 16'h8008);
    rd_i = 1; #1;
    chk("R9 pre-clear read", rd_data_o, 16'h8008);
    tick();
    chk("R1 arb cleared by read", rd_data_o, 16'h0000);

    // R2
    nak_addr_i = 1; tick();
    chk("R2 nak addr set", rd_data_o, 16'h0028);
    tick();
    chk("R2 nak addr sticky", rd_data_o, 16'h0028);
    cmd_new_i = 1; tick();
    chk("R2 cleared by new command", rd_data_o, 16'h0000);
    nak_data_i = 1; tick();
    chk("R2 nak data set", rd_data_o, 16'h0018);
    rd_i = 1; tick();
    chk("R2 nak data cleared", rd_data_o, 16'h0000);

    // R3
    timeout_i = 1; tick();
    chk("R3 timeout alone", rd_data_o, 16'h0000);
    stop_i = 1; tick();
    chk("R3 stop after timeout", rd_data_o, 16'h4008);
    rd_i = 1; tick();
    chk("R3 cleared", rd_data_o, 16'h0000);
    stop_i = 1; tick();
    chk("R3 stop without timeout", rd_data_o, 16'h0000);
    timeout_i = 1; tick();
    cmd_new_i = 1; tick();
    stop_i = 1; tick();
    chk("R3 new command cancels pending", rd_data_o, 16'h0000);

    // R5
    tx_start_i = 1; tick();
    chk("R5 tx set", rd_data_o, 16'h0002);
    rd_i = 1; tick();
    chk("R5 read before done keeps", rd_data_o, 16'h0002);
    tx_done_i = 1; rd_i = 1; tick();
    chk("R5 read with done keeps", rd_data_o, 16'h0002);
    rd_i = 1; tick();
    chk("R5 read after done clears", rd_data_o, 16'h0000);

    // R6 / R7 / R11
    tx_start_i = 1; seq_cmd_i = 1; tick();
    chk("R7 seq set", rd_data_o, 16'h0006);
    cmd_new_i = 1; tick();
    chk("R11 new command keeps busy", rd_data_o, 16'h0006);
    tx_to_rx_i = 1; tick();
    chk("R6 switch clears tx", rd_data_o, 16'h0004);
    rd_i = 1; tick();
    chk("R7 read before rx done keeps", rd_data_o, 16'h0004);
    rx_done_i = 1; tick();
    chk("R7 rx done alone keeps", rd_data_o, 16'h0004);
    rd_i = 1; tick();
    chk("R7 read after rx done clears", rd_data_o, 16'h0000);

    // R8
    arb_lost_i = 1; tick();
    arb_lost_i = 1; rd_i = 1; tick();
    chk("R8 set beats read", rd_data_o, 16'h8008);
    nak_data_i = 1; cmd_new_i = 1; tick();
    chk("R8 set beats new command", rd_data_o, 16'h0018);
    rd_i = 1; tick();
    chk("R8 then cleared", rd_data_o, 16'h0000);

    // random run against bench model (all requirements)
    for (int i = 0; i < 4000; i++) begin
      arb_lost_i = ($urandom_range(0, 19) == 0);
      nak_addr_i = ($urandom_range(0, 19) == 0);
      nak_data_i = ($urandom_range(0, 19) == 0);
      timeout_i  = ($urandom_range(0, 15) == 0);
      stop_i     = ($urandom_range(0, 7) == 0);
      tx_start_i = ($urandom_range(0, 11) == 0);
      seq_cmd_i  = ($urandom_range(0, 1) == 0);
      tx_done_i  = ($urandom_range(0, 5) == 0);
      tx_to_rx_i = ($urandom_range(0, 9) == 0);
      rx_done_i  = ($urandom_range(0, 5) == 0);
      cmd_new_i  = ($urandom_range(0, 11) == 0);
      rd_i       = ($urandom_range(0, 3) == 0);
      #1;
      chk("R9 random pre-edge word", rd_data_o, exp_word());
      tick();
      chk("R4 random word vs model", rd_data_o, exp_word());
    end

    report();
  end
endmodule